// File: doc/BRIEF.md
# Audio Sample Clock Divider Bank

This block turns one audio master clock, already locked to video at 1536 times the audio sampling rate fs, into three audio clock outputs. Each output is divided down to its own multiple of fs, picked from a fixed set of seven multiples. An eighth choice gives a block-start marker that is high for one fs period out of every `Z_BLOCK` fs periods. A 3-bit rate select can turn all three outputs off. Its non-zero values only enable the bank, because the fs value itself sets up the master clock synthesis, which lies outside this block.

All the dividers share one phase. That phase restarts at the first line of every n'th video frame, and the block marks that line with an audio frame-sync pulse of programmable polarity. The divide-by-n frame counter runs freely from reset. It can be realigned by the rising edge of an external 10-field identification reference, unless that path is disabled, and it can also be realigned by a register-driven clear pulse. Video timing arrives as single-cycle line-start and frame-start strobes in the master clock domain. The frame-start strobe coincides with the line-start of the frame's first line.

Top module: `audclk_bank`

## Requirements
- R1: Each lane with its override bit set uses its 3-bit code from `ratio_sel[3*i+2:3*i]`. The codes are: 0 gives 512fs (divide by 3), 1 gives 384fs (divide by 4), 2 gives 256fs (divide by 6), 3 gives 192fs (divide by 8), 4 gives 128fs (divide by 12), 5 gives 64fs (divide by 24), 6 gives fs (divide by 1536), and 7 gives the block-start marker. A code change takes effect on the next cycle, on the shared phase.
- R2: A lane whose override bit is clear uses its default: lane 0 runs at 256fs, lane 1 at 64fs, and lane 2 at fs.
- R3: One cycle after `rate_sel` is 000, `aud_oe` is low and every `aud_clk` bit is low. One cycle after any other value, `aud_oe` is high.
- R4: With t the number of master cycles since the last phase restart, an even divide-by-d output is high while t mod d < d/2. The 512fs output is high only when t mod 3 = 0, which gives a one-third duty cycle.
- R5: The fs output is high while t mod 1536 < 768. The block-start marker is high while floor(t/1536) mod `Z_BLOCK` = 0.
- R6: A frame start in a sync frame restarts the shared phase (t = 0) in the next cycle, so every enabled output is high in that cycle.
- R7: A frame start is a sync frame when the frame counter is 0. The counter then advances modulo `seq_len`; a `seq_len` of 0 or 1 makes every frame a sync frame. After reset the counter is 0.
- R8: The frame-sync pulse is active from the cycle after a sync-frame start up to and including the cycle of the next line start.
- R9: A rising edge of `fid_ref` while `fid_rst_dis` is low, or a high `seq_clr`, clears the frame counter, so the next frame start is a sync frame. A `fid_ref` edge while `fid_rst_dis` is high leaves the counter unchanged.
- R10: `afs` is active high when `afs_pol` is 1 and active low when it is 0, and it rests at the inactive level.
- R11: During reset the audio clocks and `aud_oe` are low, `afs` is at its inactive level, and the phase and frame counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Audio master clock at 1536 fs |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Sampling-rate select; 000 disables the clocks |
| ratio_ovr | input | NLANE | Per-lane bit that selects the ratio from `ratio_sel` rather than the default |
| ratio_sel | input | 3*NLANE | Per-lane ratio code, 3 bits per lane |
| frame_start | input | 1 | One-cycle strobe at the start of a frame's first line |
| line_start | input | 1 | One-cycle strobe at the start of every line |
| seq_len | input | SEQ_W | Number of frames n in the sync sequence |
| fid_ref | input | 1 | External 10-field identification reference |
| fid_rst_dis | input | 1 | Stops `fid_ref` from clearing the frame counter |
| seq_clr | input | 1 | Register-driven clear of the frame counter |
| afs_pol | input | 1 | Frame-sync polarity, 1 = active high |
| aud_clk | output | NLANE | Divided audio clock outputs |
| aud_oe | output | 1 | Output enable for the audio clock pins |
| afs | output | 1 | Audio frame-sync pulse |

## Verification
On every cycle, the assertions check the gating by the rate select, the all-high state that follows a phase restart, the fact that the frame-sync pulse can only start after a frame start and only end after a line start, and the polarity applied to the pulse. Only the bench scenarios can show the actual divide ratios and duty cycles, the defaults against the overrides, the long block-start period, the n-frame counting with its corner lengths 0 and 1, and the realignment by the reference edge, by the clear pulse and by neither when disabled. The bench compares every output on every cycle against a model that computes levels from the time since the last restart.

// File: rtl/audclk_pkg.sv
// Shared types and decode for the audio clock divider bank.
// Assumes a master clock of exactly 1536 fs, split into a base phase of 24
// cycles (LCM of every integer ratio) and 64 base periods per fs period.
package audclk_pkg;

    localparam int BASE_DIV = 24;
    localparam int FS_SPAN  = 64;
    localparam int C24_W    = $clog2(BASE_DIV);
    localparam int C64_W    = $clog2(FS_SPAN);

    typedef enum logic [2:0] {
        RT_512 = 3'd0,
        RT_384 = 3'd1,
        RT_256 = 3'd2,
        RT_192 = 3'd3,
        RT_128 = 3'd4,
        RT_64  = 3'd5,
        RT_1   = 3'd6,
        RT_Z   = 3'd7
    } ratio_e;

    // Reset-time ratio of a lane when its override bit is clear.
    function automatic ratio_e default_ratio(input int unsigned lane);
        case (lane)
            0:       return RT_256;
            1:       return RT_64;
            default: return RT_1;
        endcase
    endfunction

    // Output level of one ratio for a given shared phase.
    function automatic logic lane_level(input ratio_e r,
                                        input logic [C24_W-1:0] c24,
                                        input logic [C64_W-1:0] c64,
                                        input logic zfirst);
        case (r)
            RT_512:  return (c24 % 5'd3) == 5'd0;
            RT_384:  return ~c24[1];
            RT_256:  return (c24 % 5'd6) < 5'd3;
            RT_192:  return ~c24[2];
            RT_128:  return (c24 % 5'd12) < 5'd6;
            RT_64:   return c24 < 5'd12;
            RT_1:    return ~c64[C64_W-1];
            default: return zfirst;
        endcase
    endfunction

endpackage

// File: rtl/audclk_phase.sv
// Shared divider phase: a base counter modulo 24, an fs counter modulo 64
// and a block counter modulo Z_BLOCK. A restart forces all three to zero.
// Exports next-state values so that lane outputs can be registered in step.
module audclk_phase
    import audclk_pkg::*;
#(
    parameter int Z_BLOCK = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [C24_W-1:0] c24_nxt,
    output logic [C64_W-1:0] c64_nxt,
    output logic             zfirst_nxt
);
    localparam int BLK_W = (Z_BLOCK > 1) ? $clog2(Z_BLOCK) : 1;
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(Z_BLOCK - 1);
    localparam logic [C24_W-1:0] C24_LAST = C24_W'(BASE_DIV - 1);
    localparam logic [C64_W-1:0] C64_LAST = C64_W'(FS_SPAN - 1);

    logic [C24_W-1:0] c24_q;
    logic [C64_W-1:0] c64_q;
    logic [BLK_W-1:0] blk_q, blk_nxt;
    logic             base_wrap, fs_wrap;

    // Next-phase computation with restart taking priority.
    always_comb begin
        base_wrap = (c24_q == C24_LAST);
        fs_wrap   = base_wrap && (c64_q == C64_LAST);
        if (restart) begin
            c24_nxt = '0;
            c64_nxt = '0;
            blk_nxt = '0;
        end else begin
            c24_nxt = base_wrap ? '0 : c24_q + 1'b1;
            c64_nxt = base_wrap ? c64_q + 1'b1 : c64_q;
            if (fs_wrap)
                blk_nxt = (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
            else
                blk_nxt = blk_q;
        end
        zfirst_nxt = (blk_nxt == '0);
    end

    // Phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c24_q <= '0;
            c64_q <= '0;
            blk_q <= '0;
        end else begin
            c24_q <= c24_nxt;
            c64_q <= c64_nxt;
            blk_q <= blk_nxt;
        end
    end

endmodule

// File: rtl/audclk_lane.sv
// One audio clock output lane: picks its ratio (override or lane default),
// decodes the shared next phase and registers the level, gated by enable.
module audclk_lane
    import audclk_pkg::*;
#(
    parameter int unsigned LANE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ovr,
    input  logic [2:0]       sel,
    input  logic [C24_W-1:0] c24_nxt,
    input  logic [C64_W-1:0] c64_nxt,
    input  logic             zfirst_nxt,
    output logic             clk_o
);
    ratio_e eff;
    logic   lvl;

    // Effective ratio and its level for the coming cycle.
    always_comb begin
        eff = ovr ? ratio_e'(sel) : default_ratio(LANE);
        lvl = lane_level(eff, c24_nxt, c64_nxt, zfirst_nxt);
    end

    // Registered, glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_o <= 1'b0;
        else        clk_o <= en && lvl;
    end

endmodule

// File: rtl/audclk_fsync.sv
// Frame sequencer: divide-by-n frame counter, its realignment sources
// (10-field reference edge, register clear), the restart strobe for the
// dividers and the polarity-adjusted audio frame-sync pulse.
// Assumes frame_start coincides with the line_start of a frame's first line.
module audclk_fsync #(
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic [SEQ_W-1:0] seq_len,
    input  logic             fid_ref,
    input  logic             fid_rst_dis,
    input  logic             seq_clr,
    input  logic             afs_pol,
    output logic             restart,
    output logic             afs_act,
    output logic             afs_o
);
    logic [SEQ_W-1:0] fcnt_q;
    logic [SEQ_W:0]   fc_inc;
    logic             fid_d;
    logic             clr_req, seq_last, act_nxt;

    // Sync-frame decision, counter clear request and pulse next state.
    always_comb begin
        clr_req  = seq_clr || (!fid_rst_dis && fid_ref && !fid_d);
        restart  = frame_start && (fcnt_q == '0);
        fc_inc   = {1'b0, fcnt_q} + {{SEQ_W{1'b0}}, 1'b1};
        seq_last = fc_inc >= {1'b0, seq_len};
        if (restart)         act_nxt = 1'b1;
        else if (line_start) act_nxt = 1'b0;
        else                 act_nxt = afs_act;
    end

    // Frame counter, reference edge history and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q  <= '0;
            fid_d   <= 1'b0;
            afs_act <= 1'b0;
            afs_o   <= !afs_pol;
        end else begin
            if (clr_req)          fcnt_q <= '0;
            else if (frame_start) fcnt_q <= seq_last ? '0 : fc_inc[SEQ_W-1:0];
            fid_d   <= fid_ref;
            afs_act <= act_nxt;
            afs_o   <= act_nxt ~^ afs_pol;
        end
    end

endmodule

// File: rtl/audclk_bank.sv
// Audio sample clock divider bank top: one shared phase, NLANE output
// lanes, the frame sequencer and the output-enable register.
// Assumes all inputs are synchronous to the 1536 fs master clock.
module audclk_bank
    import audclk_pkg::*;
#(
    parameter int NLANE   = 3,
    parameter int Z_BLOCK = 192,
    parameter int SEQ_W   = 4
) (
    input  logic               clk_mclk,
    input  logic               rst_n,
    input  logic [2:0]         rate_sel,
    input  logic [NLANE-1:0]   ratio_ovr,
    input  logic [3*NLANE-1:0] ratio_sel,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic [SEQ_W-1:0]   seq_len,
    input  logic               fid_ref,
    input  logic               fid_rst_dis,
    input  logic               seq_clr,
    input  logic               afs_pol,
    output logic [NLANE-1:0]   aud_clk,
    output logic               aud_oe,
    output logic               afs
);
    logic             restart, afs_act, bank_en;
    logic [C24_W-1:0] c24_nxt;
    logic [C64_W-1:0] c64_nxt;
    logic             zfirst_nxt;

    assign bank_en = (rate_sel != 3'b000);

    audclk_fsync #(.SEQ_W(SEQ_W)) u_fsync (
        .clk         (clk_mclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .seq_len     (seq_len),
        .fid_ref     (fid_ref),
        .fid_rst_dis (fid_rst_dis),
        .seq_clr     (seq_clr),
        .afs_pol     (afs_pol),
        .restart     (restart),
        .afs_act     (afs_act),
        .afs_o       (afs)
    );

    audclk_phase #(.Z_BLOCK(Z_BLOCK)) u_phase (
        .clk        (clk_mclk),
        .rst_n      (rst_n),
        .restart    (restart),
        .c24_nxt    (c24_nxt),
        .c64_nxt    (c64_nxt),
        .zfirst_nxt (zfirst_nxt)
    );

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        audclk_lane #(.LANE(gi)) u_lane (
            .clk        (clk_mclk),
            .rst_n      (rst_n),
            .en         (bank_en),
            .ovr        (ratio_ovr[gi]),
            .sel        (ratio_sel[3*gi +: 3]),
            .c24_nxt    (c24_nxt),
            .c64_nxt    (c64_nxt),
            .zfirst_nxt (zfirst_nxt),
            .clk_o      (aud_clk[gi])
        );
    end

    // Output enable follows the rate select with one register stage.
    always_ff @(posedge clk_mclk) begin
        if (!rst_n) aud_oe <= 1'b0;
        else        aud_oe <= bank_en;
    end

endmodule

// File: rtl/audclk_bank_chk.sv
// Assertion checker for audclk_bank, attached by bind below.
module audclk_bank_chk #(
    parameter int NLANE = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       rate_sel,
    input logic             frame_start,
    input logic             line_start,
    input logic             afs_pol,
    input logic             restart,
    input logic             afs_act,
    input logic [NLANE-1:0] aud_clk,
    input logic             aud_oe,
    input logic             afs
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rate_sel) == 3'b000) |-> (!aud_oe && aud_clk == '0)); // R3

    AST_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rate_sel) != 3'b000) |-> aud_oe); // R3

    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(restart) && $past(rate_sel) != 3'b000) |-> (aud_clk == '1)); // R6

    AST_AFS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(afs_act)) |-> $past(frame_start)); // R8

    AST_AFS_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(afs_act)) |-> $past(line_start)); // R8

    AST_AFS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (afs == (afs_act ~^ $past(afs_pol)))); // R10
endmodule

bind audclk_bank audclk_bank_chk #(.NLANE(NLANE)) u_chk (
    .clk         (clk_mclk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .frame_start (frame_start),
    .line_start  (line_start),
    .afs_pol     (afs_pol),
    .restart     (restart),
    .afs_act     (afs_act),
    .aud_clk     (aud_clk),
    .aud_oe      (aud_oe),
    .afs         (afs)
);

// File: tb/audclk_bank_tb_top.sv
// Bench: behavioural reference model (time since restart, frame count)
// compared with every output on every cycle, plus directed checks.
module audclk_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int ZB         = 4;
    localparam int SW         = 4;
    localparam int LINE_LEN   = 40;
    localparam int FRAME_LNS  = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      rate_sel;
    logic [NL-1:0]   ratio_ovr;
    logic [3*NL-1:0] ratio_sel;
    logic            frame_start = 1'b0;
    logic            line_start  = 1'b0;
    logic [SW-1:0]   seq_len;
    logic            fid_ref, fid_rst_dis, seq_clr, afs_pol;
    logic [NL-1:0]   aud_clk;
    logic            aud_oe, afs;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  frames_on = 1'b0;
    bit  cmp_on    = 1'b0;
    bit  done      = 1'b0;
    int  lc = 0;
    int  ln = 0;

    // model state
    int  m_t = 0, m_fc = 0;
    bit  m_fidp = 0, m_act = 0, m_rs = 0;
    bit  e_oe = 0, e_afs = 0;
    bit  e_clk [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    audclk_bank #(.NLANE(NL), .Z_BLOCK(ZB), .SEQ_W(SW)) dut_i (
        .clk_mclk (clk), .rst_n (rst_n), .rate_sel (rate_sel),
        .ratio_ovr (ratio_ovr), .ratio_sel (ratio_sel),
        .frame_start (frame_start), .line_start (line_start),
        .seq_len (seq_len), .fid_ref (fid_ref), .fid_rst_dis (fid_rst_dis),
        .seq_clr (seq_clr), .afs_pol (afs_pol),
        .aud_clk (aud_clk), .aud_oe (aud_oe), .afs (afs)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Level of a ratio code at t cycles after restart (R1, R4, R5).
    function automatic bit ref_level(input int code, input int t);
        case (code)
            0: return (t % 3) == 0;
            1: return (t % 4) < 2;
            2: return (t % 6) < 3;
            3: return (t % 8) < 4;
            4: return (t % 12) < 6;
            5: return (t % 24) < 12;
            6: return (t % 1536) < 768;
            default: return ((t / 1536) % ZB) == 0;
        endcase
    endfunction

    function automatic int eff_code(input int lane);
        if (ratio_ovr[lane]) return int'(ratio_sel[3*lane +: 3]);
        return (lane == 0) ? 2 : (lane == 1) ? 5 : 6; // R2 defaults
    endfunction

    // Video timing strobes, driven away from the active edge.
    always @(negedge clk) begin
        lc = (lc == LINE_LEN-1) ? 0 : lc + 1;
        if (lc == 0) ln = (ln == FRAME_LNS-1) ? 0 : ln + 1;
        line_start  <= (lc == 0);
        frame_start <= (lc == 0) && (ln == 0) && frames_on;
    end

    // Reference model, advanced at the active edge from input values.
    always @(posedge clk) begin
        bit rr, hit;
        if (!rst_n) begin
            m_t = 0; m_fc = 0; m_fidp = 0; m_act = 0; m_rs = 0;
            e_afs = !afs_pol; e_oe = 0;
            for (int i = 0; i < NL; i++) e_clk[i] = 0;
        end else begin
            rr   = seq_clr || (!fid_rst_dis && fid_ref && !m_fidp);
            hit  = (m_fc == 0);
            m_rs = frame_start && hit;
            if (m_rs) m_act = 1;
            else if (line_start) m_act = 0;
            e_afs = afs_pol ? m_act : !m_act;
            m_t = m_rs ? 0 : m_t + 1;
            if (rr) m_fc = 0;
            else if (frame_start) m_fc = (m_fc + 1 >= int'(seq_len)) ? 0 : m_fc + 1;
            m_fidp = fid_ref;
            e_oe = (rate_sel != 0);
            for (int i = 0; i < NL; i++) e_clk[i] = e_oe && ref_level(eff_code(i), m_t);
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int i = 0; i < NL; i++)
                chk(aud_clk[i] == e_clk[i], "R1 R2 R4 R5 R6 lane", int'(aud_clk[i]), int'(e_clk[i]));
            chk(aud_oe == e_oe, "R3 oe", int'(aud_oe), int'(e_oe));
            chk(afs == e_afs, "R7 R8 R9 R10 afs", int'(afs), int'(e_afs));
            if (m_rs && e_oe)
                chk(aud_clk == '1, "R6 restart all high", int'(aud_clk), 7);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(200000 * CLK_PERIOD);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int rises;
        rst_n = 0; rate_sel = 3'd1; ratio_ovr = '0; ratio_sel = '0;
        seq_len = 4'd3; fid_ref = 0; fid_rst_dis = 0; seq_clr = 0; afs_pol = 1;
        cyc(4);
        // R11 reset state
        chk(aud_clk == '0, "R11 clocks in reset", int'(aud_clk), 0);
        chk(aud_oe == 0,   "R11 oe in reset", int'(aud_oe), 0);
        chk(afs == 0,      "R11 afs idle in reset", int'(afs), 0);
        rst_n = 1; cmp_on = 1;
        cyc(3500);                                   // R2 defaults
        ratio_ovr = 3'b111; ratio_sel = {3'd7, 3'd1, 3'd0};
        cyc(13000);                                  // R1 R4 R5: 512, 384, Z
        ratio_sel = {3'd6, 3'd4, 3'd3};
        cyc(4000);                                   // R1 R4 R5: 192, 128, fs
        ratio_sel = {3'd7, 3'd5, 3'd0};
        frames_on = 1;
        rises = 0;
        for (int k = 0; k < 3000; k++) begin         // R6 R7 R8 with n = 3
            @(negedge clk);
            if (afs && !e_afs) rises = rises;        // model compare covers mismatch
            if (m_rs) rises++;
        end
        chk(rises == 5, "R7 sync frames per 3000 cycles with n=3", rises, 5);
        seq_len = 4'd0;
        rises = 0;
        for (int k = 0; k < 1000; k++) begin         // R7 n = 0: every frame
            @(negedge clk);
            if (m_rs) rises++;
        end
        chk(rises == 5, "R7 sync frames per 1000 cycles with n=0", rises, 5);
        seq_len = 4'd5;
        cyc(1330);
        fid_ref = 1; cyc(3); fid_ref = 0;            // R9 reference edge
        cyc(2000);
        fid_rst_dis = 1; cyc(470);
        fid_ref = 1; cyc(3); fid_ref = 0;            // R9 edge ignored
        cyc(2000);
        cyc(310); seq_clr = 1; cyc(1); seq_clr = 0;  // R9 register clear
        cyc(1500);
        afs_pol = 0;                                 // R10 active low
        cyc(1200);
        rate_sel = 3'd0;                             // R3 disable
        cyc(300);
        chk(aud_oe == 0 && aud_clk == '0, "R3 disabled outputs", int'({aud_oe, aud_clk}), 0);
        rate_sel = 3'd5;
        cyc(300);
        chk(aud_oe == 1, "R3 re-enabled oe", int'(aud_oe), 1);
        rst_n = 0; cyc(2);                           // R11 mid-run reset
        chk(aud_clk == '0 && aud_oe == 0, "R11 clocks and oe in reset", int'({aud_oe, aud_clk}), 0);
        chk(afs == 1, "R11 afs idle with low polarity", int'(afs), 1);
        rst_n = 1;
        cyc(600);
        finish_run();
    end
endmodule